// File: doc/BRIEF.md
# Two-Stage Descriptor Table Walker

This block translates one address at a time by walking a hierarchy of 64-bit descriptor tables in memory. It runs either as a stage-1 walker (virtual to intermediate address) or as a stage-2-only walker (intermediate to physical address). Each descriptor fetch is one 8-byte little-endian read on a simple request/response port. The port carries no backpressure, and the block issues one request at a time.

A walk starts with a one-cycle `start` pulse that carries the input address and the access type. The translation configuration must stay stable while `busy` is high. It holds the table base, the input-size field, the granule (4 KB, 16 KB or 64 KB), an access-flag-fault disable, a hierarchical-permission disable, the stage-2 start-level select, and the input and output address limits. The block ends the walk with a one-cycle `done` pulse. The result registers then hold either a translation or a fault code with the stage it belongs to, and they keep those values until the next walk completes.

The start level comes from the input size and the granule. In stage 2 it comes from the start-level select instead. At the start level the whole index above the level shift is used. When that index is wider than one table, the extra bits select one of several adjacent start tables, each 2^stride descriptors in size.

Top module: `pt_walker`

## Requirements
- R1: Stage 1 begins at level 4 − (inputsize − 4)/stride, where inputsize = 64 − tsz and stride = granule bits − 3. Granule code 0 is 4 KB, 1 is 16 KB and 2 is 64 KB. The first descriptor is read at (base[47:0] with its low inputsize − stride·(4 − level) bits cleared) + index·8. Each later level reads at (table address) + index·8, where the index holds `stride` bits.
- R2: At a leaf (a page at level 3, descriptor bits[1:0]=11; or a block at levels 0–2, bits[1:0]=01) with no fault, the outputs are as follows. `res_pa` is descriptor bits[47:0] aligned to the level shift. `res_mask` is (1 << shift) − 1, and `res_va` is the input address with those mask bits cleared. `res_level` is the leaf level and `res_stage` is 0. A table descriptor (bits[1:0]=11 below level 3) continues the walk at the next level.
- R3: A descriptor whose bit 0 is clear, or one at level 3 with bits[1:0]=01, ends the walk with fault code 2 (translation).
- R4: In stage 1, a table descriptor with bit 62 set gives fault code 4 on a write, unless `cfg_had` is 1. Reads are not affected.
- R5: A leaf with bit 10 (access flag) clear gives fault code 3 when `cfg_affd` is 0. This check takes priority over the permission check.
- R6: In stage 1, leaf bit 7 marks the mapping read-only. A write to it gives fault code 4. `res_perm` ({write, read}) is 01 for a read-only mapping and 11 otherwise.
- R7: An error response on a descriptor read gives fault code 1, and `res_fault_addr` holds that descriptor's address.
- R8: In stage-2-only mode, an input address ≥ 2^cfg_oas gives fault code 5 with stage 1. Otherwise an input address ≥ 2^inputsize gives fault code 2 with stage 2. Neither case issues a memory read.
- R9: In stage 2 the start level is 2 − sl0 for a 4 KB granule and 3 − sl0 otherwise. The start descriptor address is base + (1 << stride)·8·t + i·8, where t is the input-address bits above the first table's index i.
- R10: In stage 2, leaf bits[7:6] are {write, read} permissions. An access they do not allow gives fault code 4, and `res_perm` equals those bits on success. A leaf output address ≥ 2^cfg_ps gives fault code 5. The checks run in the order access flag, then permission, then output size.
- R11: On any fault, `res_perm` is 00 and `res_stage` is 1 or 2 (the stage that faulted). The fault codes are 0 none, 1 external abort, 2 translation, 3 access flag, 4 permission and 5 address size.
- R12: In stage 1, an input address ≥ 2^inputsize gives fault code 2 at once, with no memory read.
- R13: After reset, `busy`, `done`, `mem_req` and `res_fault` are 0. `done` lasts one cycle. `mem_req` lasts one cycle per descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| in_addr | input | 64 | Address to translate |
| in_write | input | 1 | 1 = write access, 0 = read |
| cfg_stage2 | input | 1 | 0 = stage-1 walk, 1 = stage-2-only walk |
| cfg_ttb | input | 64 | Table base register |
| cfg_tsz | input | 6 | Input-size field (inputsize = 64 − tsz) |
| cfg_granule | input | 2 | 0 = 4 KB, 1 = 16 KB, 2 = 64 KB |
| cfg_affd | input | 1 | Disable access-flag faults |
| cfg_had | input | 1 | Disable table-level permission checks |
| cfg_sl0 | input | 2 | Stage-2 start-level select |
| cfg_oas | input | 6 | Stage-2-only input address limit (bits) |
| cfg_ps | input | 6 | Stage-2 output address limit (bits) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | PA_W | Descriptor byte address |
| mem_rsp | input | 1 | Read response valid |
| mem_rdata | input | 64 | Descriptor data |
| mem_err | input | 1 | Read response is an error |
| res_pa | output | PA_W | Output block address |
| res_va | output | 64 | Input address aligned to the block |
| res_mask | output | 64 | Block offset mask |
| res_perm | output | 2 | {write, read} permission |
| res_level | output | 2 | Leaf level |
| res_fault | output | 3 | Fault code |
| res_stage | output | 2 | Faulting stage (0 on success) |
| res_fault_addr | output | PA_W | Descriptor address of an external abort |

## Verification
The bench builds the block with the default 48-bit output address width, so all descriptor and output addresses in the test tables fit in the range the walker masks. With 4 KB and 64 KB granules and input sizes of 48, 42 and 40 bits, the bench reaches start levels 0, 1 and 2, page and block leaves at several levels, and a stage-2 start table that spans two concatenated tables. It also sets output limits of 40 and 36 bits, so one block address lands inside the range and the same block lands outside it.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_EXTABT = 3'd1,
    FLT_TRANS  = 3'd2,
    FLT_ACCESS = 3'd3,
    FLT_PERM   = 3'd4,
    FLT_ASIZE  = 3'd5
  } walk_fault_e;

  typedef enum logic [1:0] {
    DK_INVALID = 2'd0,
    DK_TABLE   = 2'd1,
    DK_LEAF    = 2'd2
  } desc_kind_e;

  // bit position of the lowest index bit used at a given level
  function automatic logic [5:0] lvl_shift(input logic [4:0] gs,
                                           input logic [3:0] st,
                                           input logic [1:0] lvl);
    return 6'(int'(gs) + (3 - int'(lvl)) * int'(st));
  endfunction
endpackage

// File: rtl/walk_geom.sv
module walk_geom (
  input  logic [1:0] granule,
  input  logic [5:0] tsz,
  input  logic [1:0] sl0,
  input  logic       stage2,
  output logic [4:0] gs,
  output logic [3:0] stride,
  output logic [6:0] isize,
  output logic [1:0] start_lvl,
  output logic [5:0] base_clr
);
  int isz, sl, clr;

  always_comb begin
    case (granule)
      2'd1:    begin gs = 5'd14; stride = 4'd11; end
      2'd2:    begin gs = 5'd16; stride = 4'd13; end
      default: begin gs = 5'd12; stride = 4'd9;  end
    endcase
    isz = 64 - int'(tsz);
    if (stage2) sl = (granule == 2'd0) ? 2 - int'(sl0) : 3 - int'(sl0);
    else        sl = 4 - (isz - 4) / int'(stride);
    if (sl < 0) sl = 0;
    if (sl > 3) sl = 3;
    clr = isz - int'(stride) * (4 - sl);
    if (clr < 0)  clr = 0;
    if (clr > 63) clr = 63;
    isize     = 7'(isz);
    start_lvl = 2'(sl);
    base_clr  = 6'(clr);
  end
endmodule

// File: rtl/walk_desc.sv
module walk_desc #(
  parameter int PA_W = 48
) (
  input  logic [63:0]       desc,
  input  logic [1:0]        lvl,
  input  logic [4:0]        gs,
  input  logic [5:0]        lshift,
  input  logic              stage2,
  input  logic              write,
  input  logic              affd,
  input  logic              had,
  input  logic [5:0]        ps,
  output walk_pkg::desc_kind_e  kind,
  output logic [PA_W-1:0]   next_base,
  output logic [PA_W-1:0]   leaf_pa,
  output logic [1:0]        leaf_perm,
  output walk_pkg::walk_fault_e leaf_fault,
  output logic              tbl_fault
);
  import walk_pkg::*;

  logic [1:0]      ap;
  logic            af, at_l3, perm_bad;
  logic [PA_W-1:0] fld;
  logic            unused_bits;

  assign unused_bits = ^{desc[63], desc[61:PA_W]};
  assign fld   = desc[PA_W-1:0];
  assign ap    = desc[7:6];
  assign af    = desc[10];
  assign at_l3 = (lvl == 2'd3);

  assign next_base = fld & ({PA_W{1'b1}} << gs);
  assign leaf_pa   = fld & ({PA_W{1'b1}} << lshift);
  assign tbl_fault = !stage2 && !had && write && desc[62];

  always_comb begin
    if (!desc[0] || (at_l3 && !desc[1])) kind = DK_INVALID;
    else if (desc[1] && !at_l3)          kind = DK_TABLE;
    else                                 kind = DK_LEAF;
  end

  always_comb begin
    if (stage2) begin
      perm_bad  = write ? !ap[1] : !ap[0];
      leaf_perm = ap;
    end else begin
      perm_bad  = write && ap[1];
      leaf_perm = ap[1] ? 2'b01 : 2'b11;
    end
    if (!af && !affd)                              leaf_fault = FLT_ACCESS;
    else if (perm_bad)                             leaf_fault = FLT_PERM;
    else if (stage2 && ((leaf_pa >> ps) != '0))    leaf_fault = FLT_ASIZE;
    else                                           leaf_fault = FLT_NONE;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [63:0]     in_addr,
  input  logic            in_write,
  input  logic            cfg_stage2,
  input  logic [63:0]     cfg_ttb,
  input  logic [5:0]      cfg_tsz,
  input  logic [1:0]      cfg_granule,
  input  logic            cfg_affd,
  input  logic            cfg_had,
  input  logic [1:0]      cfg_sl0,
  input  logic [5:0]      cfg_oas,
  input  logic [5:0]      cfg_ps,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rsp,
  input  logic [63:0]     mem_rdata,
  input  logic            mem_err,
  output logic [PA_W-1:0] res_pa,
  output logic [63:0]     res_va,
  output logic [63:0]     res_mask,
  output logic [1:0]      res_perm,
  output logic [1:0]      res_level,
  output logic [2:0]      res_fault,
  output logic [1:0]      res_stage,
  output logic [PA_W-1:0] res_fault_addr
);
  import walk_pkg::*;
  localparam int VA_W = 64;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ns, rst_meta} <= 2'b00;
    else        {rst_ns, rst_meta} <= {rst_meta, 1'b1};
  end

  st_e             st_q, st_n;
  logic [1:0]      lvl_q, lvl_n;
  logic [PA_W-1:0] base_q, base_n;
  logic [VA_W-1:0] va_q, va_n;
  logic            wr_q, wr_n, first_q, first_n, done_q;

  logic [PA_W-1:0] r_pa_q, r_pa_n, r_fa_q, r_fa_n;
  logic [VA_W-1:0] r_va_q, r_va_n, r_mask_q, r_mask_n;
  logic [1:0]      r_perm_q, r_perm_n, r_lvl_q, r_lvl_n, r_stg_q, r_stg_n;
  walk_fault_e     r_flt_q, r_flt_n;

  logic [4:0]      gs;
  logic [3:0]      stride;
  logic [6:0]      isize;
  logic [1:0]      start_lvl;
  logic [5:0]      base_clr, lshift;
  logic [VA_W-1:0] va_m, off_full, off, lmask;
  logic [PA_W-1:0] desc_addr, ttb_base, next_base, leaf_pa;
  logic [1:0]      leaf_perm;
  desc_kind_e      kind;
  walk_fault_e     leaf_fault, in_flt, f_code;
  logic            tbl_fault, in_s2, fin, ok, f_s2, walk_en;
  logic            unused_ttb;

  walk_geom u_geom (
    .granule(cfg_granule), .tsz(cfg_tsz), .sl0(cfg_sl0), .stage2(cfg_stage2),
    .gs(gs), .stride(stride), .isize(isize), .start_lvl(start_lvl),
    .base_clr(base_clr)
  );

  assign lshift = lvl_shift(gs, stride, lvl_q);

  walk_desc #(.PA_W(PA_W)) u_desc (
    .desc(mem_rdata), .lvl(lvl_q), .gs(gs), .lshift(lshift),
    .stage2(cfg_stage2), .write(wr_q), .affd(cfg_affd), .had(cfg_had),
    .ps(cfg_ps), .kind(kind), .next_base(next_base), .leaf_pa(leaf_pa),
    .leaf_perm(leaf_perm), .leaf_fault(leaf_fault), .tbl_fault(tbl_fault)
  );

  // descriptor address: the start level keeps every index bit above the
  // shift, so wide stage-2 indices step across concatenated start tables
  assign unused_ttb = ^cfg_ttb[63:PA_W];
  assign ttb_base   = cfg_ttb[PA_W-1:0] & ({PA_W{1'b1}} << base_clr);
  assign va_m       = va_q & ~({VA_W{1'b1}} << isize);
  assign off_full   = va_m >> lshift;
  assign off        = first_q ? off_full : (off_full & ~({VA_W{1'b1}} << stride));
  assign desc_addr  = base_q + PA_W'(off << 3);
  assign lmask      = ~({VA_W{1'b1}} << lshift);

  assign busy     = (st_q != ST_IDLE);
  assign mem_req  = (st_q == ST_REQ);
  assign mem_addr = desc_addr;
  assign done     = done_q;

  // input range checks made before any memory read
  always_comb begin
    in_flt = FLT_NONE;
    in_s2  = 1'b0;
    if (cfg_stage2) begin
      if ((in_addr >> cfg_oas) != '0) in_flt = FLT_ASIZE;
      else if ((in_addr >> isize) != '0) begin
        in_flt = FLT_TRANS;
        in_s2  = 1'b1;
      end
    end else if ((in_addr >> isize) != '0) begin
      in_flt = FLT_TRANS;
    end
  end

  assign walk_en = ((st_q == ST_IDLE) && start) || ((st_q == ST_WAIT) && mem_rsp)
                   || (st_q == ST_REQ);

  always_comb begin
    st_n = st_q; lvl_n = lvl_q; base_n = base_q; va_n = va_q;
    wr_n = wr_q; first_n = first_q;
    fin = 1'b0; ok = 1'b0; f_code = FLT_NONE; f_s2 = cfg_stage2;
    case (st_q)
      ST_IDLE: if (start) begin
        va_n = in_addr;
        wr_n = in_write;
        if (in_flt != FLT_NONE) begin
          fin = 1'b1; f_code = in_flt; f_s2 = in_s2;
        end else begin
          lvl_n = start_lvl; base_n = ttb_base; first_n = 1'b1; st_n = ST_REQ;
        end
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: if (mem_rsp) begin
        if (mem_err) begin
          fin = 1'b1; f_code = FLT_EXTABT;
        end else begin
          case (kind)
            DK_TABLE:
              if (tbl_fault) begin
                fin = 1'b1; f_code = FLT_PERM;
              end else begin
                base_n = next_base; lvl_n = lvl_q + 2'd1; first_n = 1'b0;
                st_n = ST_REQ;
              end
            DK_LEAF: begin
              fin = 1'b1; f_code = leaf_fault; ok = (leaf_fault == FLT_NONE);
            end
            default: begin fin = 1'b1; f_code = FLT_TRANS; end
          endcase
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin) st_n = ST_IDLE;

    r_flt_n  = f_code;
    r_stg_n  = ok ? 2'd0 : (f_s2 ? 2'd2 : 2'd1);
    r_perm_n = ok ? leaf_perm : 2'b00;
    r_pa_n   = ok ? leaf_pa : '0;
    r_va_n   = ok ? (va_q & ~lmask) : '0;
    r_mask_n = ok ? lmask : '0;
    r_lvl_n  = ok ? lvl_q : 2'd0;
    r_fa_n   = (f_code == FLT_EXTABT) ? desc_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE; lvl_q <= '0; base_q <= '0; va_q <= '0;
      wr_q <= 1'b0; first_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (walk_en) begin
        st_q <= st_n; lvl_q <= lvl_n; base_q <= base_n; va_q <= va_n;
        wr_q <= wr_n; first_q <= first_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      r_flt_q <= FLT_NONE; r_stg_q <= '0; r_perm_q <= '0; r_pa_q <= '0;
      r_va_q <= '0; r_mask_q <= '0; r_lvl_q <= '0; r_fa_q <= '0;
    end else if (fin) begin
      r_flt_q <= r_flt_n; r_stg_q <= r_stg_n; r_perm_q <= r_perm_n;
      r_pa_q <= r_pa_n; r_va_q <= r_va_n; r_mask_q <= r_mask_n;
      r_lvl_q <= r_lvl_n; r_fa_q <= r_fa_n;
    end
  end

  assign res_pa = r_pa_q;   assign res_va = r_va_q;     assign res_mask = r_mask_q;
  assign res_perm = r_perm_q; assign res_level = r_lvl_q; assign res_fault = r_flt_q;
  assign res_stage = r_stg_q; assign res_fault_addr = r_fa_q;

  // R11: a faulting walk grants nothing and names a stage
  p_fault_no_perm_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && res_fault != 3'd0) |-> (res_perm == 2'b00 && res_stage != 2'd0));
  // R2: a successful result is aligned to its own block size
  p_leaf_aligned_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && res_fault == 3'd0) |->
      ((res_va & res_mask) == '0 && (res_pa & res_mask[PA_W-1:0]) == '0));
  // R13: each descriptor read request lasts one cycle
  p_req_single_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req |=> !mem_req);
  // R13: completion is a single-cycle pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);
  // R7: an external abort reports the address that was being read
  p_abort_addr_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && res_fault == 3'd1) |-> (res_fault_addr == $past(mem_addr)));
  // R8: an out-of-range input completes at once without a read
  p_input_fault_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && start && in_flt != FLT_NONE) |=> (done && !mem_req));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, in_write = 1'b0, cfg_stage2 = 1'b0;
  logic [63:0] in_addr = '0, cfg_ttb = '0;
  logic [5:0]  cfg_tsz = 6'd16, cfg_oas = 6'd44, cfg_ps = 6'd40;
  logic [1:0]  cfg_granule = 2'd0, cfg_sl0 = 2'd0;
  logic        cfg_affd = 1'b0, cfg_had = 1'b0;
  logic        mem_rsp = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done, mem_req;
  logic [47:0] mem_addr, res_pa, res_fault_addr;
  logic [63:0] res_va, res_mask;
  logic [1:0]  res_perm, res_level, res_stage;
  logic [2:0]  res_fault;

  int vectors = 0, misses = 0, nreq = 0;
  bit finished = 0;
  logic [63:0] mem [logic [47:0]];
  logic [47:0] err_addr = '1;

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_addr(in_addr),
    .in_write(in_write), .cfg_stage2(cfg_stage2), .cfg_ttb(cfg_ttb),
    .cfg_tsz(cfg_tsz), .cfg_granule(cfg_granule), .cfg_affd(cfg_affd),
    .cfg_had(cfg_had), .cfg_sl0(cfg_sl0), .cfg_oas(cfg_oas), .cfg_ps(cfg_ps),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp(mem_rsp), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .res_pa(res_pa), .res_va(res_va), .res_mask(res_mask),
    .res_perm(res_perm), .res_level(res_level), .res_fault(res_fault),
    .res_stage(res_stage), .res_fault_addr(res_fault_addr)
  );

  // memory model: answers one negedge after the request
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp = 1'b0; mem_err = 1'b0;
      if (mem_req) begin
        logic [47:0] a;
        a = mem_addr;
        nreq++;
        @(negedge clk);
        mem_rsp   = 1'b1;
        mem_err   = (a == err_addr);
        mem_rdata = mem.exists(a) ? mem[a] : 64'd0;
      end
    end
  end

  function automatic logic [63:0] ix(input logic [63:0] v, input int sh, input int bits);
    return (v >> sh) & ((64'd1 << bits) - 64'd1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic wr);
    int t = 0;
    nreq = 0;
    @(negedge clk);
    in_addr = va; in_write = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    if (!done) chk("R13 walk timeout", 64'd0, 64'd1);
  endtask

  task automatic expect_fault(input string tag, input logic [2:0] f, input logic [1:0] s);
    chk({tag, " fault"}, 64'(res_fault), 64'(f));
    chk({tag, " stage"}, 64'(res_stage), 64'(s));
    chk({tag, " perm none (R11)"}, 64'(res_perm), 64'd0);
  endtask

  localparam logic [63:0] VA1 = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] AF  = 64'h400;

  task automatic s1_cfg();
    cfg_stage2 = 0; cfg_tsz = 6'd16; cfg_granule = 2'd0; cfg_ttb = 64'h10000;
    cfg_affd = 0; cfg_had = 0; err_addr = '1;
  endtask

  task automatic build_4k(input logic [63:0] l3desc);
    mem.delete();
    mem[48'h10000 + 48'(ix(VA1,39,9)*8)] = 64'h20003;
    mem[48'h20000 + 48'(ix(VA1,30,9)*8)] = 64'h30003;
    mem[48'h30000 + 48'(ix(VA1,21,9)*8)] = 64'h40003;
    mem[48'h40000 + 48'(ix(VA1,12,9)*8)] = l3desc;
  endtask

  task automatic t_reset();
    chk("R13 reset busy", 64'(busy), 0);
    chk("R13 reset done", 64'(done), 0);
    chk("R13 reset mem_req", 64'(mem_req), 0);
    chk("R13 reset fault", 64'(res_fault), 0);
  endtask

  task automatic t_page();  // R1 R2 R13
    s1_cfg(); build_4k(64'hABCD_E000 | AF | 64'h3);
    walk(VA1, 1'b1);
    chk("R1 four reads", nreq, 4);
    chk("R2 pa", 64'(res_pa), 64'hABCD_E000);
    chk("R2 va", res_va, VA1 & ~64'hFFF);
    chk("R2 mask", res_mask, 64'hFFF);
    chk("R6 perm rw", 64'(res_perm), 64'b11);
    chk("R2 level", 64'(res_level), 3);
    chk("R2 stage", 64'(res_stage), 0);
    chk("R11 fault none", 64'(res_fault), 0);
    @(negedge clk);
    chk("R13 done one cycle", 64'(done), 0);
  endtask

  task automatic t_block();  // R2
    s1_cfg(); build_4k(0);
    mem[48'h20000 + 48'(ix(VA1,30,9)*8)] = 64'h4000_0000 | AF | 64'h1;
    walk(VA1, 1'b0);
    chk("R2 block reads", nreq, 2);
    chk("R2 block pa", 64'(res_pa), 64'h4000_0000);
    chk("R2 block mask", res_mask, 64'h3FFF_FFFF);
    chk("R2 block va", res_va, VA1 & ~64'h3FFF_FFFF);
    chk("R2 block level", 64'(res_level), 1);
  endtask

  task automatic t_af_perm();  // R5 R6
    s1_cfg(); build_4k(64'hABCD_E000 | 64'h80 | 64'h3);
    walk(VA1, 1'b1);
    expect_fault("R5 af before perm", 3'd3, 2'd1);
    cfg_affd = 1;
    walk(VA1, 1'b1);
    expect_fault("R6 write ro", 3'd4, 2'd1);
    walk(VA1, 1'b0);
    chk("R6 read ro fault", 64'(res_fault), 0);
    chk("R6 read ro perm", 64'(res_perm), 64'b01);
  endtask

  task automatic t_invalid();  // R3
    s1_cfg(); build_4k(64'hABCD_E000 | AF | 64'h1);
    walk(VA1, 1'b0);
    expect_fault("R3 reserved l3", 3'd2, 2'd1);
    mem[48'h30000 + 48'(ix(VA1,21,9)*8)] = 64'h40002;
    walk(VA1, 1'b0);
    expect_fault("R3 invalid l2", 3'd2, 2'd1);
    chk("R3 stops at l2", nreq, 3);
  endtask

  task automatic t_aptable();  // R4
    s1_cfg(); build_4k(64'hABCD_E000 | AF | 64'h3);
    mem[48'h10000 + 48'(ix(VA1,39,9)*8)] = 64'h4000_0000_0002_0003;
    walk(VA1, 1'b1);
    expect_fault("R4 aptable write", 3'd4, 2'd1);
    walk(VA1, 1'b0);
    chk("R4 aptable read ok", 64'(res_fault), 0);
    cfg_had = 1;
    walk(VA1, 1'b1);
    chk("R4 had write ok", 64'(res_fault), 0);
    chk("R4 had pa", 64'(res_pa), 64'hABCD_E000);
  endtask

  task automatic t_abort();  // R7
    s1_cfg(); build_4k(64'hABCD_E000 | AF | 64'h3);
    err_addr = 48'h20000 + 48'(ix(VA1,30,9)*8);
    walk(VA1, 1'b0);
    expect_fault("R7 abort", 3'd1, 2'd1);
    chk("R7 abort addr", 64'(res_fault_addr), 64'(err_addr));
    err_addr = '1;
  endtask

  task automatic t_s1_range();  // R12
    s1_cfg();
    walk(64'h1 << 48, 1'b0);
    expect_fault("R12 s1 range", 3'd2, 2'd1);
    chk("R12 no reads", nreq, 0);
  endtask

  task automatic t_64k();  // R1
    logic [63:0] va;
    va = 64'h0000_02AB_CDEF_1234;
    s1_cfg(); cfg_granule = 2'd2; cfg_tsz = 6'd22; cfg_ttb = 64'h10_0000;
    mem.delete();
    mem[48'h10_0000 + 48'(ix(va,29,13)*8)] = 64'h20_0003;
    mem[48'h20_0000 + 48'(ix(va,16,13)*8)] = 64'h7_6543_0000 | AF | 64'h3;
    walk(va, 1'b0);
    chk("R1 64k reads", nreq, 2);
    chk("R1 64k pa", 64'(res_pa), 64'h7_6543_0000);
    chk("R1 64k mask", res_mask, 64'hFFFF);
    chk("R1 64k level", 64'(res_level), 3);
  endtask

  task automatic t_s2();  // R8 R9 R10
    logic [63:0] ipa;
    logic [47:0] l1;
    ipa = 64'h0000_00C0_1234_5678;
    cfg_stage2 = 1; cfg_granule = 2'd0; cfg_tsz = 6'd24; cfg_sl0 = 2'd1;
    cfg_oas = 6'd44; cfg_ps = 6'd40; cfg_ttb = 64'h8_0000; cfg_affd = 0; cfg_had = 0;
    l1 = 48'h8_0000 + 48'((64'd1 << 9) * 8 * ix(ipa,39,1)) + 48'(ix(ipa,30,9) * 8);
    mem.delete();
    mem[l1] = 64'h9_0003;
    mem[48'h9_0000 + 48'(ix(ipa,21,9)*8)] = 64'h12_3440_0000 | AF | 64'h40 | 64'h1;
    walk(ipa, 1'b0);
    chk("R9 s2 reads", nreq, 2);
    chk("R9 s2 fault", 64'(res_fault), 0);
    chk("R9 s2 pa", 64'(res_pa), 64'h12_3440_0000);
    chk("R9 s2 level", 64'(res_level), 2);
    chk("R10 s2 perm", 64'(res_perm), 64'b01);
    walk(ipa, 1'b1);
    expect_fault("R10 s2 write", 3'd4, 2'd2);
    cfg_ps = 6'd36;
    walk(ipa, 1'b0);
    expect_fault("R10 out size", 3'd5, 2'd2);
    walk(64'h1 << 41, 1'b0);
    expect_fault("R8 s2 isize", 3'd2, 2'd2);
    chk("R8 isize no reads", nreq, 0);
    walk(64'h1 << 45, 1'b0);
    expect_fault("R8 oas", 3'd5, 2'd1);
    chk("R8 oas no reads", nreq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_page();
    t_block();
    t_af_perm();
    t_invalid();
    t_aptable();
    t_abort();
    t_s1_range();
    t_64k();
    t_s2();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule